// File: doc/BRIEF.md
# Serial sampling converter control sequencer

This block is the digital sequencer of a multiplexed serial successive-approximation converter. It runs on the serial clock supplied by the host and is framed by an active-low chip select and an active-high shutdown. While a frame runs, it takes the input-channel selection bits from the serial data input and holds them for the following conversion. It drives the sample/hold control and steps a 12-bit successive-approximation trial word, one bit per clock, from a single comparator bit. It streams the result out MSB first with a separate output-enable that the pad uses as its tri-state control. A status output marks the span of each conversion.

Two ways of running share one frame counter. In triggered operation the host raises chip select between frames, and each falling edge of chip select starts a 16-clock conversion. In continuous operation chip select stays low and every frame is 17 clocks long. The extra clock is idle and sits between the last clock of one frame and the first clock of the next. The capacitor DAC and the comparator are outside the block: the trial word goes to the DAC, and one comparator bit comes back.

Top module: `adc_serial_seq`

## Requirements
- R1: While chip select is high, without waiting for a clock edge, the output-enable, status and hold outputs are all low, and the next falling edge of chip select starts a frame at clock 1.
- R2: When chip select falls with shutdown low, hold and status go high before any serial clock edge occurs.
- R3: On the rising edges of frame clocks 1 and 2, the data input is shifted in MSB first. The channel output takes the new 2-bit code at rising edge 2, so it applies to the next conversion. Chip select and shutdown leave it unchanged.
- R4: The output-enable is low until the falling edge of clock 4. It is high after the falling edges of clocks 4 to 15 and low again after the falling edge of clock 16.
- R5: The data output carries result bit 11 after the falling edge of clock 4, down to bit 0 after the falling edge of clock 15. Each bit changes only on falling edges.
- R6: Rising edge 2 loads the trial word with 0x800. Rising edge 14-i keeps bit i if the comparator bit is 1, clears it otherwise, and sets bit i-1 as the next trial. After rising edge 14 the trial word equals the binary-search result.
- R7: While active, hold is low (sample mode) from the falling edge of clock 15 to the falling edge of clock 17, which is two clock periods. It is high at all other times.
- R8: With chip select held low, rising edge 17 is an idle clock with the output disabled, and the rising edge after it is clock 1 of the next frame.
- R9: Status goes low after the falling edge of clock 16 and high again after the falling edge of clock 17.
- R10: Raising shutdown aborts any frame at once, exactly as a high chip select does, and keeps the channel selection. Once shutdown falls with chip select low, a new frame starts at clock 1.
- R11: A low rst_n clears the channel selection to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low; high clears the sequencer |
| shdn | input | 1 | Shutdown, active high; aborts the frame |
| din | input | 1 | Serial input carrying channel-select bits |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial level |
| trial_o | output | 12 | Trial/result word driving the capacitor DAC |
| chan_o | output | 2 | Selected input channel |
| hold_o | output | 1 | 1 = hold, 0 = sample |
| status_o | output | 1 | High while a conversion is under way |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for the data pad |

## Verification
A frame counter one step off moves the whole data window, which shows at the first falling edge of clock 4 as an early or late enable. A wrong trial bit shows up as a wrong data bit about one clock after the rising edge on which that bit was resolved. A channel code held in the wrong register, or cleared by chip select, appears as the wrong channel output at rising edge 2. It also means a different conversion value is picked for the next frame. The reference model follows the ideal comparator and checks every output shortly before every rising edge, so each such fault is reported within one clock of its first visible effect.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // clocks in a frame before the first result bit leaves the pad
  localparam int BLANK_CLKS = 4;
  // sample-mode span between conversions, in serial clocks
  localparam int ACQ_CLKS = 2;

  function automatic int frame_clks(input int nbits);
    return BLANK_CLKS + nbits;
  endfunction
endpackage

// File: rtl/adc_seq_frame_ctr.sv
module adc_seq_frame_ctr #(
  parameter int LAST = 17,
  parameter int CW   = 5
) (
  input  logic          clk,
  input  logic          arst_n,
  output logic [CW-1:0] pos_o,
  output logic [CW-1:0] edge_o
);
  logic [CW-1:0] pos_q, pos_d;

  always_comb begin
    if (pos_q == CW'(LAST)) pos_d = CW'(1);
    else                    pos_d = pos_q + CW'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_o  = pos_q;
  assign edge_o = pos_d;
endmodule

// File: rtl/adc_seq_mux_cfg.sv
module adc_seq_mux_cfg #(
  parameter int W  = 2,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          din_i,
  input  logic [CW-1:0] edge_i,
  output logic [W-1:0]  chan_o
);
  logic [W-1:0] cfg_d;
  logic [W-1:0] chan_q;
  logic         load_en;

  assign load_en = active_i && (edge_i == CW'(W));

  generate
    if (W == 1) begin : g_single
      assign cfg_d = din_i;
    end else begin : g_shift
      logic [W-2:0] part_q;
      logic         shift_en;
      assign shift_en = active_i && (edge_i >= CW'(1)) && (edge_i < CW'(W));
      assign cfg_d    = {part_q, din_i};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        part_q <= '0;
        else if (shift_en) part_q <= cfg_d[W-2:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chan_q <= '0;
    else if (load_en) chan_q <= cfg_d;
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
  parameter int NB = 12,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [CW-1:0] edge_i,
  input  logic          cmp_i,
  output logic [NB-1:0] trial_o
);
  import adc_seq_pkg::*;
  localparam int START = BLANK_CLKS - 2;
  localparam int FIRST = START + 1;
  localparam int LASTR = START + NB;

  logic [NB-1:0] trial_q, trial_d;
  logic          sar_en;
  int            idx;

  always_comb begin
    trial_d = trial_q;
    idx     = LASTR - int'(edge_i);
    sar_en  = 1'b0;
    if (edge_i == CW'(START)) begin
      sar_en           = 1'b1;
      trial_d          = '0;
      trial_d[NB-1]    = 1'b1;
    end else if ((edge_i >= CW'(FIRST)) && (edge_i <= CW'(LASTR))) begin
      sar_en = 1'b1;
      for (int b = 0; b < NB; b++) begin
        if (b == idx)     trial_d[b] = cmp_i;
        if (b == idx - 1) trial_d[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     trial_q <= '0;
    else if (sar_en) trial_q <= trial_d;
  end

  assign trial_o = trial_q;
endmodule

// File: rtl/adc_seq_out_stage.sv
module adc_seq_out_stage #(
  parameter int NB = 12,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [CW-1:0] pos_i,
  input  logic [NB-1:0] trial_i,
  output logic          dout_o,
  output logic          oe_o,
  output logic          done_o,
  output logic          acq_o
);
  import adc_seq_pkg::*;
  localparam int OUT_FIRST = BLANK_CLKS;
  localparam int OUT_LAST  = BLANK_CLKS + NB - 1;
  localparam int DONE_AT   = frame_clks(NB);
  localparam int LAST      = DONE_AT + 1;
  localparam int ACQ_AT    = DONE_AT - ACQ_CLKS + 1;

  logic dout_q, dout_d, oe_q, oe_d, done_q, done_d, acq_q, acq_d;

  always_comb begin
    oe_d   = (pos_i >= CW'(OUT_FIRST)) && (pos_i <= CW'(OUT_LAST));
    dout_d = dout_q;
    if (oe_d) begin
      for (int b = 0; b < NB; b++)
        if (b == OUT_LAST - int'(pos_i)) dout_d = trial_i[b];
    end
    done_d = done_q;
    if (pos_i == CW'(DONE_AT))   done_d = 1'b1;
    else if (pos_i == CW'(LAST)) done_d = 1'b0;
    acq_d = acq_q;
    if (pos_i == CW'(ACQ_AT))    acq_d = 1'b1;
    else if (pos_i == CW'(LAST)) acq_d = 1'b0;
  end

  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      acq_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      oe_q   <= oe_d;
      done_q <= done_d;
      acq_q  <= acq_d;
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;
  assign done_o = done_q;
  assign acq_o  = acq_q;
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq #(
  parameter int NBITS = 12,
  parameter int NCH   = 4,
  localparam int MUXW = (NCH > 2) ? $clog2(NCH) : 1
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             shdn,
  input  logic             din,
  input  logic             cmp_i,
  output logic [NBITS-1:0] trial_o,
  output logic [MUXW-1:0]  chan_o,
  output logic             hold_o,
  output logic             status_o,
  output logic             dout_o,
  output logic             dout_oe_o
);
  import adc_seq_pkg::*;
  localparam int LAST = frame_clks(NBITS) + 1;
  localparam int CW   = $clog2(LAST + 1);

  logic          active;
  logic [CW-1:0] pos_w, edge_w;
  logic          done_w, acq_w;

  // chip select high, shutdown or power-on reset clear the frame at once
  assign active = rst_n & ~cs_n & ~shdn;

  adc_seq_frame_ctr #(.LAST(LAST), .CW(CW)) u_ctr (
    .clk(sclk), .arst_n(active), .pos_o(pos_w), .edge_o(edge_w)
  );

  adc_seq_mux_cfg #(.W(MUXW), .CW(CW)) u_mux (
    .clk(sclk), .rst_n(rst_n), .active_i(active), .din_i(din),
    .edge_i(edge_w), .chan_o(chan_o)
  );

  adc_seq_sar #(.NB(NBITS), .CW(CW)) u_sar (
    .clk(sclk), .arst_n(active), .edge_i(edge_w), .cmp_i(cmp_i),
    .trial_o(trial_o)
  );

  adc_seq_out_stage #(.NB(NBITS), .CW(CW)) u_out (
    .clk(sclk), .arst_n(active), .pos_i(pos_w), .trial_i(trial_o),
    .dout_o(dout_o), .oe_o(dout_oe_o), .done_o(done_w), .acq_o(acq_w)
  );

  assign hold_o   = active & ~acq_w;
  assign status_o = active & ~done_w;
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk #(
  parameter int NBITS = 12,
  parameter int MUXW  = 2,
  parameter int CW    = 5
) (
  input logic             sclk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             shdn,
  input logic             active,
  input logic [CW-1:0]    pos_w,
  input logic [MUXW-1:0]  chan_o,
  input logic [NBITS-1:0] trial_o,
  input logic             hold_o,
  input logic             status_o,
  input logic             dout_oe_o
);
  import adc_seq_pkg::*;
  localparam int OUT_FIRST = BLANK_CLKS;
  localparam int OUT_LAST  = BLANK_CLKS + NBITS - 1;
  localparam int DONE_AT   = frame_clks(NBITS);
  localparam int LAST      = DONE_AT + 1;
  localparam int ACQ_AT    = DONE_AT - ACQ_CLKS + 1;
  localparam logic [NBITS-1:0] MSB_TRIAL = {1'b1, {(NBITS-1){1'b0}}};

  assert_idle_R1: assert property (@(posedge sclk) disable iff (!rst_n)
    (cs_n || shdn) |-> (!dout_oe_o && !status_o && !hold_o));

  assert_chan_stable_R3: assert property (@(posedge sclk) disable iff (!active)
    (pos_w >= CW'(MUXW) && pos_w < CW'(LAST)) |=> $stable(chan_o));

  assert_blank_R4: assert property (@(posedge sclk) disable iff (!active)
    (pos_w < CW'(OUT_FIRST) || pos_w > CW'(OUT_LAST)) |-> !dout_oe_o);

  assert_trial_msb_R6: assert property (@(posedge sclk) disable iff (!active)
    (pos_w == CW'(BLANK_CLKS - 3)) |=> (trial_o == MSB_TRIAL));

  assert_hold_R7: assert property (@(posedge sclk) disable iff (!active)
    (pos_w < CW'(ACQ_AT) || pos_w == CW'(LAST)) |-> hold_o);

  assert_status_low_R9: assert property (@(posedge sclk) disable iff (!active)
    (pos_w == CW'(DONE_AT)) |-> !status_o);
endmodule

bind adc_serial_seq adc_serial_seq_chk #(.NBITS(NBITS), .MUXW(MUXW), .CW(CW)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .shdn(shdn), .active(active),
  .pos_w(pos_w), .chan_o(chan_o), .trial_o(trial_o), .hold_o(hold_o),
  .status_o(status_o), .dout_oe_o(dout_oe_o)
);

// File: tb/adc_serial_seq_bench.sv
module adc_serial_seq_bench;
  localparam int NB  = 12;
  localparam int NCH = 4;
  localparam int MW  = 2;

  logic sclk = 1'b0;
  always #5 sclk = ~sclk;

  logic          rst_n, cs_n, shdn, din, cmp;
  logic [NB-1:0] trial;
  logic [MW-1:0] chan;
  logic          hold, status, dout, oe;

  logic [NB-1:0] cur_vin;
  logic [NB-1:0] vin_tbl [NCH];
  int            k;
  logic [MW-1:0] exp_chan, sh;
  int            n_cmp, n_bad;

  // ideal comparator against the DAC trial word
  assign cmp = (cur_vin >= trial);

  adc_serial_seq #(.NBITS(NB), .NCH(NCH)) u_adc_serial_seq (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .shdn(shdn), .din(din),
    .cmp_i(cmp), .trial_o(trial), .chan_o(chan), .hold_o(hold),
    .status_o(status), .dout_o(dout), .dout_oe_o(oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (clock %0d, t=%0t)", req, act, exp, k, $time);
    end
  endtask

  task automatic compare();
    bit on;
    on = rst_n && !cs_n && !shdn;
    chk(rst_n ? "R3 channel" : "R11 channel", chan, exp_chan);
    if (!on) begin
      chk(shdn ? "R10 oe" : "R1 oe", oe, 0);
      chk(shdn ? "R10 status" : "R1 status", status, 0);
      chk(shdn ? "R10 hold" : "R1 hold", hold, 0);
    end else begin
      chk(k == 17 ? "R8 dead clock oe" : "R4 oe", oe, (k >= 4 && k <= 15));
      if (k >= 4 && k <= 15) chk("R5 data bit", dout, cur_vin[15-k]);
      chk(k == 0 ? "R2 status" : "R9 status", status, (k != 16));
      chk(k == 0 ? "R2 hold" : "R7 hold", hold, !(k == 15 || k == 16));
      if (k == 2) chk("R6 first trial", trial, 12'h800);
      if (k >= 14) chk("R6 result", trial, cur_vin);
    end
  endtask

  task automatic cyc(input logic c, input logic s, input logic d);
    bit changed;
    @(negedge sclk);
    #2 compare();
    #1;
    changed = (c != cs_n) || (s != shdn);
    cs_n = c; shdn = s; din = d;
    if (changed) begin
      if (!(rst_n && !cs_n && !shdn)) k = 0;
      #1 compare();
    end
    @(posedge sclk);
    #1;
    if (!rst_n) begin
      k = 0; exp_chan = '0; sh = '0;
    end else if (cs_n || shdn) begin
      k = 0;
    end else begin
      k = (k == 17) ? 1 : k + 1;
      if (k == 1) cur_vin = vin_tbl[exp_chan];
      if (k >= 1 && k <= MW) begin
        sh = {sh[MW-2:0], din};
        if (k == MW) exp_chan = sh;
      end
    end
  endtask

  task automatic frame(input logic [MW-1:0] nxt, input int nclk);
    for (int j = 1; j <= nclk; j++)
      cyc(1'b0, 1'b0, (j <= MW) ? nxt[MW-j] : 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; k = 0; exp_chan = '0; sh = '0;
    vin_tbl[0] = 12'h7FF; vin_tbl[1] = 12'h000;
    vin_tbl[2] = 12'hFFF; vin_tbl[3] = 12'hA5C;
    cur_vin = '0;
    rst_n = 1'b0; cs_n = 1'b1; shdn = 1'b0; din = 1'b0;
    // R11: reset state
    repeat (3) cyc(1'b1, 1'b0, 1'b0);
    @(negedge sclk); rst_n = 1'b1;
    repeat (2) cyc(1'b1, 1'b0, 1'b0);

    // triggered frames: R2 on chip select fall, R3 channel for next frame
    frame(2'd3, 16); cyc(1'b1, 1'b0, 1'b0);
    frame(2'd2, 16); cyc(1'b1, 1'b0, 1'b0); cyc(1'b1, 1'b0, 1'b0);
    frame(2'd1, 16); cyc(1'b1, 1'b0, 1'b0);
    frame(2'd0, 16); cyc(1'b1, 1'b0, 1'b0);
    // R1: abort mid frame with chip select
    frame(2'd2, 9);  cyc(1'b1, 1'b0, 1'b0); cyc(1'b1, 1'b0, 1'b0);
    frame(2'd3, 16); cyc(1'b1, 1'b0, 1'b0);

    // continuous frames: R8 dead clock, R9 status framing
    frame(2'd1, 17);
    frame(2'd2, 17);
    frame(2'd3, 17);
    frame(2'd0, 17);
    frame(2'd2, 17);
    // R10: shutdown mid frame, channel kept, fresh frame after release
    frame(2'd1, 7);
    repeat (3) cyc(1'b0, 1'b1, 1'b0);
    frame(2'd3, 17);
    frame(2'd1, 17);
    frame(2'd0, 17);

    // R11: reset in the middle of a run clears the channel
    cyc(1'b1, 1'b0, 1'b0);
    @(negedge sclk); rst_n = 1'b0;
    cyc(1'b1, 1'b0, 1'b0);
    @(negedge sclk); rst_n = 1'b1;
    cyc(1'b1, 1'b0, 1'b0);
    frame(2'd2, 16); cyc(1'b1, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule